// File: doc/BRIEF.md
# Supply Supervisor with Reset Extension and Backup Switchover

This block is a digital supply supervisor. It receives three asynchronous flags from analog comparators. The first says the main supply is below the power-fail trip level. The second says the main supply is below the higher of the two backup batteries. The third says which battery is higher. Each flag is brought into the clock domain through a two-stage synchronizer. From the synchronized flags the block drives four things: an active-low system reset, a gate on the chip enable going to an external SRAM, an internal signal that blocks register and RAM access, and a code that selects the supply source.

Reset goes low as soon as the synchronized trip flag is seen. After the supply recovers, reset stays low for a set number of slow ticks. The ticks come from a clock-enable input, and the default count gives about 100 ms with a 1 kHz tick. The supply source moves to a battery only when the main supply is below both the trip level and the larger battery. That one rule covers both cases: trip level above the batteries and trip level below them. All pins are plain control and status lines. There is no streamed data, so no valid/ready handshake is used.

Top module: `supply_guard`

## Requirements
- R1: `rst_out_n` is low in every cycle in which the synchronized trip flag is set, and the trip flag reaches the outputs two clock edges after the raw input changes.
- R2: After the synchronized trip flag clears, `rst_out_n` stays low until exactly RECOVER_TICKS cycles have been counted with `tick_en` high. It goes high on the clock edge that counts the last of those ticks.
- R3: A new trip while the recovery count is running sets the count back to zero. A full RECOVER_TICKS ticks are then needed after the next recovery.
- R4: While the synchronized trip flag is set, `ce_out_n` is 1 (inactive) whatever `ce_in_n` is, and `access_block` is 1.
- R5: While the synchronized trip flag is clear, `ce_out_n` equals `ce_in_n` in the same cycle and `access_block` is 0.
- R6: `src_sel` uses these codes: 0 for the main supply, 1 for the primary battery, 2 for the auxiliary battery. It is nonzero only when both the synchronized trip flag and the synchronized below-battery flag are set.
- R7: When a battery is selected, `src_sel` is 2 if the aux-higher flag is set and 1 otherwise.
- R8: While `rst_n` is low, `rst_out_n` is 0, `access_block` is 1, `ce_out_n` is 1 and `src_sel` is 0. After `rst_n` is released with no fault present, a full recovery count is served before `rst_out_n` goes high.
- R9: Without `tick_en` pulses the recovery count does not advance, so `rst_out_n` stays low however many clock cycles pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Supervisor clock |
| rst_n | input | 1 | Asynchronous active-low reset of the supervisor logic |
| tick_en | input | 1 | Slow clock enable that paces the recovery count |
| below_trip_raw | input | 1 | Comparator flag: main supply below the power-fail trip level (async) |
| below_batt_raw | input | 1 | Comparator flag: main supply below the larger battery (async) |
| aux_high_raw | input | 1 | Comparator flag: auxiliary battery above primary battery (async) |
| ce_in_n | input | 1 | Active-low SRAM chip enable from the host |
| rst_out_n | output | 1 | Active-low system reset |
| ce_out_n | output | 1 | Active-low SRAM chip enable, gated during power fail |
| access_block | output | 1 | High while internal register and RAM accesses must be refused |
| src_sel | output | 2 | Supply source code: 0 main, 1 primary battery, 2 auxiliary battery |

## Verification
The bench measures the recovery hold to the exact edge. A timer that is off by one releases reset a cycle early or a cycle late. It also sends a short trip pulse while the count is running. A design that keeps the partial count releases reset too soon after that pulse. Power fail is set up both with and without the below-battery flag. A design that switches on the trip flag alone would select a battery while the main supply still sits above the batteries. The bench also paces the ticks slowly and then stops them, so a timer that counts raw clock cycles instead of ticks is caught.

// File: rtl/supply_guard_pkg.sv
package supply_guard_pkg;
  typedef enum logic [1:0] {
    SRC_MAIN = 2'd0,
    SRC_PRI  = 2'd1,
    SRC_AUX  = 2'd2
  } src_t;

  localparam int unsigned FLAG_N     = 3;
  localparam int unsigned FLAG_TRIP  = 0;
  localparam int unsigned FLAG_BATT  = 1;
  localparam int unsigned FLAG_AUXHI = 2;
endpackage

// File: rtl/sg_flag_sync.sv
// Two-stage synchronizer bank; each lane has its own reset value.
module sg_flag_sync #(
  parameter int unsigned        WIDTH   = 3,
  parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_lane
    logic meta_q, sync_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= RST_VAL[g];
        sync_q <= RST_VAL[g];
      end else begin
        meta_q <= d_async[g];
        sync_q <= meta_q;
      end
    end
    assign q_sync[g] = sync_q;
  end
endmodule

// File: rtl/sg_recovery_timer.sv
// Holds reset for RECOVER_TICKS enabled ticks after the fault clears.
module sg_recovery_timer #(
  parameter int unsigned RECOVER_TICKS = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fault,
  input  logic tick_en,
  output logic hold
);
  localparam int unsigned CNT_W = (RECOVER_TICKS < 2) ? 1 : $clog2(RECOVER_TICKS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(RECOVER_TICKS - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      hold_q <= 1'b1;
    end else if (fault) begin
      cnt_q  <= '0;
      hold_q <= 1'b1;
    end else if (hold_q && tick_en) begin
      if (cnt_q == LAST) begin
        hold_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign hold = hold_q;
endmodule

// File: rtl/sg_source_select.sv
// Battery only when main is below both trip level and larger battery.
module sg_source_select
  import supply_guard_pkg::*;
(
  input  logic below_trip,
  input  logic below_batt,
  input  logic aux_high,
  output src_t src
);
  always_comb begin
    if (below_trip && below_batt) src = aux_high ? SRC_AUX : SRC_PRI;
    else                          src = SRC_MAIN;
  end
endmodule

// File: rtl/supply_guard.sv
module supply_guard
  import supply_guard_pkg::*;
#(
  parameter int unsigned RECOVER_TICKS = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic       below_trip_raw,
  input  logic       below_batt_raw,
  input  logic       aux_high_raw,
  input  logic       ce_in_n,
  output logic       rst_out_n,
  output logic       ce_out_n,
  output logic       access_block,
  output logic [1:0] src_sel
);
  // Fail-safe reset values: trip and below-battery start asserted.
  localparam logic [FLAG_N-1:0] FLAG_RST = FLAG_N'(3'b011);

  logic [FLAG_N-1:0] raw_flags, sync_flags;
  logic              hold;
  logic              in_reset;
  src_t              src;

  assign raw_flags[FLAG_TRIP]  = below_trip_raw;
  assign raw_flags[FLAG_BATT]  = below_batt_raw;
  assign raw_flags[FLAG_AUXHI] = aux_high_raw;

  sg_flag_sync #(.WIDTH(FLAG_N), .RST_VAL(FLAG_RST)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (raw_flags),
    .q_sync  (sync_flags)
  );

  sg_recovery_timer #(.RECOVER_TICKS(RECOVER_TICKS)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .fault   (sync_flags[FLAG_TRIP]),
    .tick_en (tick_en),
    .hold    (hold)
  );

  sg_source_select u_src (
    .below_trip (sync_flags[FLAG_TRIP]),
    .below_batt (sync_flags[FLAG_BATT]),
    .aux_high   (sync_flags[FLAG_AUXHI]),
    .src        (src)
  );

  // Source select is forced to main while the supervisor itself is reset.
  assign in_reset     = !rst_n;
  assign access_block = sync_flags[FLAG_TRIP];
  assign rst_out_n    = !(sync_flags[FLAG_TRIP] || hold);
  assign ce_out_n     = sync_flags[FLAG_TRIP] ? 1'b1 : ce_in_n;
  assign src_sel      = in_reset ? SRC_MAIN : src;
endmodule

// File: rtl/supply_guard_chk.sv
module supply_guard_chk #(
  parameter int unsigned RECOVER_TICKS = 100
) (
  input logic       clk,
  input logic       rst_n,
  input logic       tick_en,
  input logic       ce_in_n,
  input logic       rst_out_n,
  input logic       ce_out_n,
  input logic       access_block,
  input logic [1:0] src_sel
);
  logic [31:0] ticks_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        ticks_seen <= '0;
    else if (access_block)             ticks_seen <= '0;
    else if (tick_en && !rst_out_n)    ticks_seen <= ticks_seen + 1;
  end

  assert_rst_in_fail_R1: assert property (@(posedge clk) disable iff (!rst_n)
    access_block |-> !rst_out_n);

  assert_release_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_out_n) |-> ticks_seen == RECOVER_TICKS);

  assert_release_on_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_out_n) |-> $past(tick_en));

  assert_ce_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    access_block |-> ce_out_n);

  assert_ce_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !access_block |-> ce_out_n == ce_in_n);

  assert_src_only_fail_R6: assert property (@(posedge clk) disable iff (!rst_n)
    src_sel != 2'd0 |-> access_block);

  assert_src_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
    src_sel != 2'd3);
endmodule

bind supply_guard supply_guard_chk #(.RECOVER_TICKS(RECOVER_TICKS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .tick_en      (tick_en),
  .ce_in_n      (ce_in_n),
  .rst_out_n    (rst_out_n),
  .ce_out_n     (ce_out_n),
  .access_block (access_block),
  .src_sel      (src_sel)
);

// File: tb/supply_guard_bench.sv
module supply_guard_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N          = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b1;
  logic       trip = 1'b0, batt = 1'b0, auxhi = 1'b0, ce_in_n = 1'b1;
  logic       rst_out_n, ce_out_n, access_block;
  logic [1:0] src_sel;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  supply_guard #(.RECOVER_TICKS(N)) u_supply_guard (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .below_trip_raw(trip), .below_batt_raw(batt), .aux_high_raw(auxhi),
    .ce_in_n(ce_in_n), .rst_out_n(rst_out_n), .ce_out_n(ce_out_n),
    .access_block(access_block), .src_sel(src_sel)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // Bring the block to normal operation: no fault, reset released.
  task automatic recover_fully();
    trip = 0; batt = 0; tick_en = 1;
    edges(2 + N);
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    check("R8 rst_out_n in reset", rst_out_n, 0);
    check("R8 access_block in reset", access_block, 1);
    check("R8 ce_out_n in reset", ce_out_n, 1);
    check("R8 src_sel in reset", src_sel, 0);
    rst_n = 1;
    edges(2 + N - 1);
    check("R8 still held one tick before end", rst_out_n, 0);
    check("R8 block cleared after sync", access_block, 0);
    edges(1);
    check("R8 released after full count", rst_out_n, 1);
  endtask

  task automatic t_fail_sources();
    ce_in_n = 0; trip = 1; batt = 1; auxhi = 0;
    edges(1);
    check("R1 not yet seen after one edge", rst_out_n, 1);
    edges(1);
    check("R1 rst low on trip", rst_out_n, 0);
    check("R4 block in fail", access_block, 1);
    check("R4 ce forced inactive", ce_out_n, 1);
    check("R7 primary selected", src_sel, 1);
    auxhi = 1;
    edges(2);
    check("R7 aux selected", src_sel, 2);
    recover_fully();
    check("R6 main after recovery", src_sel, 0);
  endtask

  task automatic t_trip_above_batt();
    trip = 1; batt = 0; auxhi = 1;
    edges(2);
    check("R6 main kept, trip above batteries", src_sel, 0);
    check("R1 rst low", rst_out_n, 0);
    recover_fully();
    trip = 0; batt = 1;
    edges(2);
    check("R6 main kept, only below battery", src_sel, 0);
    check("R5 no block", access_block, 0);
    ce_in_n = 0; #1;
    check("R5 ce follows low", ce_out_n, 0);
    ce_in_n = 1; #1;
    check("R5 ce follows high", ce_out_n, 1);
    batt = 0;
    edges(2);
  endtask

  task automatic t_restart();
    trip = 1; edges(2);
    trip = 0; edges(2 + 3);
    check("R3 mid count still low", rst_out_n, 0);
    trip = 1; edges(2);
    check("R3 new trip seen", access_block, 1);
    trip = 0;
    edges(2 + N - 1);
    check("R3 count restarted, low", rst_out_n, 0);
    edges(1);
    check("R3 released after full count", rst_out_n, 1);
  endtask

  task automatic t_slow_tick();
    int cnt = 0;
    int bad = 0;
    trip = 1; edges(2);
    trip = 0;
    for (int i = 1; i <= 40; i++) begin
      tick_en = (i % 3 == 0);
      @(posedge clk);
      if (i > 2 && tick_en) cnt++;
      @(negedge clk);
      if (rst_out_n != (cnt >= N)) bad++;
    end
    check("R2 slow tick release timing", bad, 0);
    check("R2 released after slow ticks", rst_out_n, 1);
    tick_en = 1;
  endtask

  task automatic t_no_tick();
    trip = 1; edges(2);
    tick_en = 0; trip = 0;
    edges(200);
    check("R9 held without ticks", rst_out_n, 0);
    check("R9 block cleared", access_block, 0);
    tick_en = 1;
    edges(N);
    check("R9 released once ticks return", rst_out_n, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset_state();
    t_fail_sources();
    t_trip_above_batt();
    t_restart();
    t_slow_tick();
    t_no_tick();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule